// File: doc/BRIEF.md
# Byte-framed register access controller

This block turns a stream of command bytes into single accesses on a simple on-chip register bus and returns a framed reply for every command it accepts. Bytes come in on a valid/ready input, one per handshake. A command opens with the marker 0x55, carries a command code, optional address and data bytes, and closes with the marker 0xAA. The block checks the frame, performs the bus access or core reset, and then streams the reply out on a valid/ready output. A reply opens with 0xAA and closes with 0x55.

Back-pressure works in both directions. On the input side, a byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from the closing byte of a frame until the reply has been sent in full, so only one command is in flight at a time. On the output side, a byte moves only when `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending byte stays on `out_byte` unchanged. The bus side is a plain strobe interface. Read data must be valid in the cycle after the strobe.

Top module: `frame_bridge`

## Requirements
- R1: While idle, every accepted byte other than 0x55 is discarded. It produces no reply and no bus access.
- R2: The write frame is 0x55, 0x11, two address bytes (high first), four data bytes (most significant first), 0xAA. It causes exactly one bus strobe with `bus_wen` high, carrying that address and data. The reply is 0xAA, 0x7E, the address high byte, the address low byte, 0x55.
- R3: The read frame is 0x55, 0x10, two address bytes (high first), 0xAA. It causes exactly one bus strobe with `bus_wen` low. The reply is 0xAA, 0x7F, the two address bytes, the four bytes of read data (bits 31:24 first, bits 7:0 last), 0x55.
- R4: The frame 0x55, 0x01, 0xAA drives `core_rst` high for exactly one cycle and makes no bus access. The reply is 0xAA, 0x7D, 0x55.
- R5: If the byte after 0x55 is a code other than 0x10, 0x11 or 0x01, the frame ends at that byte. The reply is 0xAA, 0xFE, that code, 0x55, and no bus access is made. Bytes after the reply are treated as idle bytes.
- R6: If the byte where the closing 0xAA is expected holds any other value, the reply is 0xAA, 0xFD, that byte, 0x55. No bus access is made.
- R7: `in_ready` is low while a reply byte is pending. A reply byte held by low `out_ready` keeps `out_valid` high and `out_byte` unchanged. Every reply begins with 0xAA.
- R8: During and right after reset, `in_ready` is 1, and `out_valid`, `bus_sel` and `core_rst` are 0.
- R9: `bus_sel` is never high for two consecutive cycles. `bus_wen` is high only together with `bus_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_byte | input | 8 | Command byte |
| in_ready | output | 1 | Block accepts a command byte |
| out_valid | output | 1 | Reply byte present |
| out_byte | output | 8 | Reply byte |
| out_ready | input | 1 | Receiver takes the reply byte |
| bus_sel | output | 1 | One-cycle access strobe |
| bus_wen | output | 1 | Strobe is a write |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after the strobe |
| core_rst | output | 1 | One-cycle reset pulse to the cores |

## Verification
If the frame parser loses its place, it shows up as a missing reply, a stray bus strobe, or a reply with the wrong echoed address. All of these appear within the few cycles after the closing byte. If read data is captured in the wrong cycle, the data bytes of the reply are wrong. A stuck transmit index either repeats or skips reply bytes, or leaves `in_ready` low for good, so the next command stalls. The bench sends commands under both free-flowing and throttled output and compares every reply byte in order. It also counts strobes and reset pulses around each command, so an access that should not happen is caught as soon as its frame ends.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // command side markers and codes
  localparam logic [7:0] CMD_SOF   = 8'h55;
  localparam logic [7:0] CMD_EOF   = 8'hAA;
  localparam logic [7:0] OP_READ   = 8'h10;
  localparam logic [7:0] OP_WRITE  = 8'h11;
  localparam logic [7:0] OP_RESET  = 8'h01;
  // reply side markers and status codes
  localparam logic [7:0] RSP_SOF   = 8'hAA;
  localparam logic [7:0] RSP_EOF   = 8'h55;
  localparam logic [7:0] ST_READ   = 8'h7F;
  localparam logic [7:0] ST_WRITE  = 8'h7E;
  localparam logic [7:0] ST_RESET  = 8'h7D;
  localparam logic [7:0] ST_UNKNOWN = 8'hFE;
  localparam logic [7:0] ST_ERROR  = 8'hFD;

  typedef enum logic [2:0] {
    FK_READ, FK_WRITE, FK_RESET, FK_UNKNOWN, FK_BADEND
  } frame_kind_e;
endpackage

// File: rtl/fb_rx.sv
// Command frame collector: walks the frame, latches its fields and
// holds them until the reply has gone out.
module fb_rx
  import fb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  input  logic              resume,
  output logic              done,
  output frame_kind_e       kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [7:0]        bad_byte
);
  localparam int AB    = ADDR_W / 8;
  localparam int DB    = DATA_W / 8;
  localparam int MAXB  = (AB > DB) ? AB : DB;
  localparam int CNT_W = $clog2(MAXB) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CODE, S_ADDR, S_DATA, S_END, S_HOLD} rx_state_e;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign in_ready = (state != S_HOLD);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      kind     <= FK_READ;
      addr     <= '0;
      wdata    <= '0;
      bad_byte <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_HOLD) begin
        if (resume) state <= S_IDLE;
      end else if (accept) begin
        case (state)
          S_IDLE: if (in_byte == CMD_SOF) state <= S_CODE;
          S_CODE: begin
            bad_byte <= in_byte;
            cnt      <= '0;
            case (in_byte)
              OP_READ:  begin kind <= FK_READ;  state <= S_ADDR; end
              OP_WRITE: begin kind <= FK_WRITE; state <= S_ADDR; end
              OP_RESET: begin kind <= FK_RESET; state <= S_END;  end
              default:  begin kind <= FK_UNKNOWN; state <= S_HOLD; done <= 1'b1; end
            endcase
          end
          S_ADDR: begin
            addr <= {addr[ADDR_W-9:0], in_byte};
            if (cnt == CNT_W'(AB - 1)) begin
              cnt   <= '0;
              state <= (kind == FK_WRITE) ? S_DATA : S_END;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            wdata <= {wdata[DATA_W-9:0], in_byte};
            if (cnt == CNT_W'(DB - 1)) begin
              cnt   <= '0;
              state <= S_END;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_END: begin
            bad_byte <= in_byte;
            if (in_byte != CMD_EOF) kind <= FK_BADEND;
            state <= S_HOLD;
            done  <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fb_fmt.sv
// Reply formatter: lays out the reply bytes, first byte in the top lane.
module fb_fmt
  import fb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NBYTES = 3 + ADDR_W / 8 + DATA_W / 8,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  frame_kind_e         kind,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [7:0]          bad_byte,
  output logic [NBYTES*8-1:0] flat,
  output logic [LEN_W-1:0]    len
);
  localparam int AB = ADDR_W / 8;
  localparam int DB = DATA_W / 8;

  logic [7:0] rb [NBYTES];

  always_comb begin
    for (int i = 0; i < NBYTES; i++) rb[i] = 8'h00;
    rb[0] = RSP_SOF;
    len   = LEN_W'(4);
    case (kind)
      FK_READ: begin
        rb[1] = ST_READ;
        for (int i = 0; i < AB; i++) rb[2 + i] = addr[(AB - 1 - i) * 8 +: 8];
        for (int j = 0; j < DB; j++) rb[2 + AB + j] = rdata[(DB - 1 - j) * 8 +: 8];
        rb[2 + AB + DB] = RSP_EOF;
        len = LEN_W'(3 + AB + DB);
      end
      FK_WRITE: begin
        rb[1] = ST_WRITE;
        for (int i = 0; i < AB; i++) rb[2 + i] = addr[(AB - 1 - i) * 8 +: 8];
        rb[2 + AB] = RSP_EOF;
        len = LEN_W'(3 + AB);
      end
      FK_RESET: begin
        rb[1] = ST_RESET;
        rb[2] = RSP_EOF;
        len   = LEN_W'(3);
      end
      FK_UNKNOWN, FK_BADEND: begin
        rb[1] = (kind == FK_UNKNOWN) ? ST_UNKNOWN : ST_ERROR;
        rb[2] = bad_byte;
        rb[3] = RSP_EOF;
        len   = LEN_W'(4);
      end
      default: len = LEN_W'(4);
    endcase
    for (int i = 0; i < NBYTES; i++) flat[(NBYTES - 1 - i) * 8 +: 8] = rb[i];
  end
endmodule

// File: rtl/fb_tx.sv
// Reply serializer: steps through the formatted bytes under out_ready.
module fb_tx #(
  parameter int NBYTES = 9,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NBYTES*8-1:0] flat,
  input  logic [LEN_W-1:0]    len,
  output logic                out_valid,
  output logic [7:0]          out_byte,
  input  logic                out_ready,
  output logic                done
);
  logic             active;
  logic [LEN_W-1:0] idx;

  assign out_valid = active;

  always_comb begin
    out_byte = 8'h00;
    for (int i = 0; i < NBYTES; i++)
      if (idx == LEN_W'(i)) out_byte = flat[(NBYTES - 1 - i) * 8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active && out_ready) begin
        if (idx == len - LEN_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_bridge.sv
module frame_bridge
  import fb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  input  logic              out_ready,
  output logic              bus_sel,
  output logic              bus_wen,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              core_rst
);
  localparam int NBYTES = 3 + ADDR_W / 8 + DATA_W / 8;
  localparam int LEN_W  = $clog2(NBYTES + 1);

  frame_kind_e         kind;
  logic                frame_done, tx_done, capture_stage;
  logic [7:0]          bad_byte;
  logic [DATA_W-1:0]   rdata_q;
  logic [NBYTES*8-1:0] flat;
  logic [LEN_W-1:0]    len;

  fb_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .resume(tx_done), .done(frame_done), .kind(kind),
    .addr(bus_addr), .wdata(bus_wdata), .bad_byte(bad_byte)
  );

  // strobe in the cycle after the closing byte, data sampled one cycle later
  assign bus_sel  = frame_done && (kind == FK_READ || kind == FK_WRITE);
  assign bus_wen  = frame_done && (kind == FK_WRITE);
  assign core_rst = frame_done && (kind == FK_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capture_stage <= 1'b0;
      rdata_q       <= '0;
    end else begin
      capture_stage <= frame_done;
      if (capture_stage && kind == FK_READ) rdata_q <= bus_rdata;
    end
  end

  fb_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES), .LEN_W(LEN_W)) u_fmt (
    .kind(kind), .addr(bus_addr), .rdata(rdata_q), .bad_byte(bad_byte),
    .flat(flat), .len(len)
  );

  fb_tx #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(capture_stage), .flat(flat), .len(len),
    .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready), .done(tx_done)
  );
endmodule

// File: rtl/fb_checks.sv
module fb_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_ready,
  input logic       bus_sel,
  input logic       bus_wen,
  input logic       core_rst
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R8: assert (!out_valid && in_ready && !bus_sel && !core_rst)
        else $error("outputs not quiet in reset");
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  assert_no_intake_while_replying_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_reply_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_byte == 8'hAA);

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> !bus_sel);

  assert_wen_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen |-> bus_sel);

  assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);

  assert_reset_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !bus_sel);
endmodule

bind frame_bridge fb_checks u_fb_checks (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_byte(out_byte), .out_ready(out_ready), .bus_sel(bus_sel),
  .bus_wen(bus_wen), .core_rst(core_rst)
);

// File: tb/test_frame_bridge.sv
`timescale 1ns/1ps
module test_frame_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_ready;
  logic        bus_sel, bus_wen, core_rst;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  always #2.5 clk = ~clk;

  frame_bridge i_frame_bridge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_byte(out_byte),
    .out_ready(out_ready), .bus_sel(bus_sel), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_rst(core_rst)
  );

  int total = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // register bus model: 16 words, read data one cycle after the strobe
  function automatic logic [31:0] init_word(input int i);
    return {8'hA5, 8'(i), 8'h3C, 8'(i * 3)};
  endfunction

  logic [31:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = init_word(i);
  always @(posedge clk) begin
    if (bus_sel && bus_wen) mem[bus_addr[3:0]] <= bus_wdata;
    if (bus_sel && !bus_wen) bus_rdata <= mem[bus_addr[3:0]];
  end
  initial bus_rdata = 32'h0;

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         throttle = 1'b0;
  int         strobes = 0, wide_sel = 0, rst_pulses = 0, wide_rst = 0, busy_viol = 0;
  logic [15:0] last_addr;
  logic [31:0] last_wdata;
  logic        last_wen;

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  initial begin
    int cyc = 0;
    bit prev_sel = 1'b0, prev_rst = 1'b0;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = throttle ? (cyc % 3 == 0) : 1'b1;
      if (rst_n) begin
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected reply byte", {24'h0, out_byte}, 32'h0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_byte == e, t, {24'h0, out_byte}, {24'h0, e});
          end
        end
        if (out_valid && in_ready) busy_viol++;
        if (bus_sel) begin
          strobes++;
          last_addr = bus_addr;
          last_wdata = bus_wdata;
          last_wen = bus_wen;
          if (prev_sel) wide_sel++;
        end
        if (core_rst) begin
          rst_pulses++;
          if (prev_rst) wide_rst++;
        end
        prev_sel = bus_sel;
        prev_rst = core_rst;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_reply;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    expect_byte(8'hAA, "R2"); expect_byte(8'h7E, "R2");
    expect_byte(a[15:8], "R2"); expect_byte(a[7:0], "R2"); expect_byte(8'h55, "R2");
    send(8'h55); send(8'h11); send(a[15:8]); send(a[7:0]);
    send(d[31:24]); send(d[23:16]); send(d[15:8]); send(d[7:0]); send(8'hAA);
    wait_reply();
  endtask

  task automatic do_read(input logic [15:0] a, input logic [31:0] d);
    expect_byte(8'hAA, "R3"); expect_byte(8'h7F, "R3");
    expect_byte(a[15:8], "R3"); expect_byte(a[7:0], "R3");
    expect_byte(d[31:24], "R3"); expect_byte(d[23:16], "R3");
    expect_byte(d[15:8], "R3"); expect_byte(d[7:0], "R3"); expect_byte(8'h55, "R3");
    send(8'h55); send(8'h10); send(a[15:8]); send(a[7:0]); send(8'hAA);
    wait_reply();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    // R8: state while reset is held
    chk(in_ready == 1'b1, "R8 in_ready", {31'h0, in_ready}, 32'h1);
    chk(out_valid == 1'b0, "R8 out_valid", {31'h0, out_valid}, 32'h0);
    chk(bus_sel == 1'b0, "R8 bus_sel", {31'h0, bus_sel}, 32'h0);
    chk(core_rst == 1'b0, "R8 core_rst", {31'h0, core_rst}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready after release", {31'h0, in_ready}, 32'h1);

    // R1: idle garbage is dropped
    send(8'h00); send(8'hAA); send(8'h11); send(8'h7F);
    repeat (6) @(negedge clk);
    chk(strobes == 0, "R1 no strobe from idle bytes", strobes, 0);
    chk(out_valid == 1'b0, "R1 no reply from idle bytes", {31'h0, out_valid}, 32'h0);

    // R2: write, bus fields
    do_write(16'h0003, 32'hDEADBEEF);
    chk(strobes == 1, "R2 one strobe", strobes, 1);
    chk(last_addr == 16'h0003, "R2 address", {16'h0, last_addr}, 32'h3);
    chk(last_wdata == 32'hDEADBEEF, "R2 write data", last_wdata, 32'hDEADBEEF);
    chk(last_wen == 1'b1, "R2 wen", {31'h0, last_wen}, 32'h1);

    // R3: read back and read an untouched word
    do_read(16'h0003, 32'hDEADBEEF);
    chk(strobes == 2 && last_wen == 1'b0, "R3 read strobe", strobes, 2);
    do_read(16'h1205, init_word(5));
    chk(last_addr == 16'h1205, "R3 address", {16'h0, last_addr}, 32'h1205);

    // R7: throttled output
    throttle = 1'b1;
    do_write(16'hA007, 32'h01234567);
    do_read(16'hA007, 32'h01234567);
    do_read(16'h000F, init_word(15));
    throttle = 1'b0;

    // R4: core reset
    s0 = strobes; r0 = rst_pulses;
    expect_byte(8'hAA, "R4"); expect_byte(8'h7D, "R4"); expect_byte(8'h55, "R4");
    send(8'h55); send(8'h01); send(8'hAA);
    wait_reply();
    chk(rst_pulses == r0 + 1, "R4 one reset pulse", rst_pulses, r0 + 1);
    chk(wide_rst == 0, "R4 pulse width", wide_rst, 0);
    chk(strobes == s0, "R4 no bus access", strobes, s0);

    // R5: unknown code, trailing byte then idles
    s0 = strobes;
    expect_byte(8'hAA, "R5"); expect_byte(8'hFE, "R5");
    expect_byte(8'h42, "R5"); expect_byte(8'h55, "R5");
    send(8'h55); send(8'h42);
    wait_reply();
    send(8'hAA);
    repeat (6) @(negedge clk);
    chk(strobes == s0, "R5 no bus access", strobes, s0);
    chk(out_valid == 1'b0, "R5 trailing byte dropped", {31'h0, out_valid}, 32'h0);

    // R6: wrong closing byte, read and write frames
    expect_byte(8'hAA, "R6"); expect_byte(8'hFD, "R6");
    expect_byte(8'h33, "R6"); expect_byte(8'h55, "R6");
    send(8'h55); send(8'h10); send(8'h00); send(8'h01); send(8'h33);
    wait_reply();
    expect_byte(8'hAA, "R6"); expect_byte(8'hFD, "R6");
    expect_byte(8'h55, "R6"); expect_byte(8'h55, "R6");
    send(8'h55); send(8'h11); send(8'h00); send(8'h02);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'h55);
    wait_reply();
    chk(strobes == s0, "R6 no bus access", strobes, s0);
    do_read(16'h0002, init_word(2));

    // R7 / R9 summaries
    chk(busy_viol == 0, "R7 in_ready low while replying", busy_viol, 0);
    chk(wide_sel == 0, "R9 single-cycle strobe", wide_sel, 0);
    chk(exp_q.size() == 0, "R7 all reply bytes seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule